// File: doc/BRIEF.md
# Streaming Ready-Latency Adapter

This block joins two valid/ready streams that differ in ready latency. On the upstream side the source may send only in a cycle that follows an asserted `up_ready` by exactly `LAT` cycles. On the downstream side a beat moves only in a cycle where `dn_valid` and `dn_ready` are both high. Each beat carries a data word together with a channel field and an error field. The three fields stay together from input to output.

Once the adapter has raised `up_ready`, it has committed to accept a beat `LAT` cycles later. A shift register keeps a record of the recent `up_ready` values, and its oldest entry marks the current cycle as a ready cycle. The beats that have been promised but have not yet arrived are counted against the free space in an internal FIFO and its output register. As a result, a stall on the downstream side can never cause a committed beat to be lost. A source that drives `up_valid` outside a ready cycle is ignored. That event is reported one cycle later on `up_proto_err`.

Top module: `stream_latency_bridge`

## Requirements
- R1: While `rst` is high, `up_ready` is low. `dn_valid` is low in the first cycle after a cycle with `rst` high. In the first cycle after reset is released, `up_ready` is high and `dn_valid` is low.
- R2: An upstream beat is accepted only when `up_valid` is high in a ready cycle. A ready cycle is a cycle in which `up_ready` was high exactly `LAT` cycles earlier.
- R3: Stored beats plus beats still due inside the latency window never exceed the capacity of FIFO depth + 1. `up_ready` is raised only when one more beat still fits. No committed beat is lost under any downstream stall pattern.
- R4: When `up_valid` is high in a cycle that is not a ready cycle, the beat is ignored and `up_proto_err` is high in the next cycle. In every other case `up_proto_err` is low.
- R5: A downstream beat leaves only in a cycle where `dn_valid` and `dn_ready` are both high. While `dn_valid` is high and `dn_ready` is low, the next cycle keeps `dn_valid` high and keeps `dn_data`, `dn_chan` and `dn_err` unchanged.
- R6: Beats leave in exactly their arrival order. Each beat's data, channel and error values appear together on the output, packed as {data, chan, err}.
- R7: The upstream data, channel and error inputs are never captured in a cycle where `up_valid` is low, whatever their values.
- R8: With `dn_ready` held high and the source sending in every ready cycle, `up_ready` stays high in every cycle, so one beat per cycle passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| up_ready | output | 1 | Upstream credit; a beat may follow LAT cycles later |
| up_valid | input | 1 | Upstream beat valid |
| up_data | input | DATA_W | Upstream data word |
| up_chan | input | CHAN_W | Upstream channel field |
| up_err | input | ERR_W | Upstream error field |
| up_proto_err | output | 1 | Valid seen outside a ready cycle, one cycle earlier |
| dn_valid | output | 1 | Downstream beat present |
| dn_ready | input | 1 | Downstream sink accepts |
| dn_data | output | DATA_W | Downstream data word |
| dn_chan | output | CHAN_W | Downstream channel field |
| dn_err | output | ERR_W | Downstream error field |

## Verification
Two things can fall in the same cycle: a promised beat arrives from upstream, and the output register is emptied by the downstream side while the store sits at full capacity. The bench provokes this by running the source at every ready cycle while `dn_ready` follows an LFSR, alternates, or stays low. The result is judged by comparing every departing beat with an ordered scoreboard and by bounding the scoreboard depth by the capacity. Illegal valids are also injected into non-ready cycles, sometimes in the same cycle as a stalled output, and each one must raise the error flag without producing an extra beat.

// File: rtl/slb_pkg.sv
package slb_pkg;
  // Storage depth: power of two holding at least LAT+2 beats so that the
  // latency window plus one stored beat never throttles a full-rate stream.
  function automatic int slb_depth(input int lat);
    return 1 << $clog2(lat + 2);
  endfunction
endpackage

// File: rtl/slb_ready_hist.sv
module slb_ready_hist #(
  parameter int LAT = 2,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ready_now,
  output logic          ready_cycle,
  output logic [CW-1:0] inflight
);
  logic [LAT-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= (hist << 1) | LAT'(ready_now);
  end

  // oldest entry: ready was high exactly LAT cycles ago
  assign ready_cycle = hist[LAT-1];
  // every credit still outstanding, including the one landing now
  assign inflight    = CW'($countones(hist));
endmodule

// File: rtl/slb_fifo.sv
module slb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int OW = $clog2(DEPTH + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_beat,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_beat,
  output logic [OW-1:0] occupancy
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          pop_out, load;

  assign pop_out = out_valid & out_ready;
  assign load    = (cnt != '0) & (~out_valid | pop_out);

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_beat;
  end

  always_ff @(posedge clk) begin
    if (load) out_beat <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_en) wptr <= wptr + 1'b1;
      if (load)  rptr <= rptr + 1'b1;
      cnt <= cnt + (AW+1)'(wr_en) - (AW+1)'(load);
      if (load)         out_valid <= 1'b1;
      else if (pop_out) out_valid <= 1'b0;
    end
  end

  assign occupancy = OW'(cnt) + OW'(out_valid);
endmodule

// File: rtl/stream_latency_bridge.sv
module stream_latency_bridge #(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 2,
  parameter int ERR_W  = 1,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic              up_ready,
  input  logic              up_valid,
  input  logic [DATA_W-1:0] up_data,
  input  logic [CHAN_W-1:0] up_chan,
  input  logic [ERR_W-1:0]  up_err,
  output logic              up_proto_err,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data,
  output logic [CHAN_W-1:0] dn_chan,
  output logic [ERR_W-1:0]  dn_err
);
  localparam int DEPTH = slb_pkg::slb_depth(LAT);
  localparam int CAP   = DEPTH + 1;
  localparam int BW    = DATA_W + CHAN_W + ERR_W;
  localparam int CW    = $clog2(LAT + 1);
  localparam int OW    = $clog2(DEPTH + 2);

  logic          ready_cycle;
  logic [CW-1:0] inflight;
  logic [OW-1:0] occ;
  logic          wr;
  logic [BW-1:0] out_beat;

  slb_ready_hist #(.LAT(LAT)) u_hist (
    .clk         (clk),
    .rst         (rst),
    .ready_now   (up_ready),
    .ready_cycle (ready_cycle),
    .inflight    (inflight)
  );

  assign wr = up_valid & ready_cycle;

  slb_fifo #(.W(BW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr),
    .wr_beat   ({up_data, up_chan, up_err}),
    .out_ready (dn_ready),
    .out_valid (dn_valid),
    .out_beat  (out_beat),
    .occupancy (occ)
  );

  // credit from registered state only: stored + promised + this one
  assign up_ready = ~rst & ((int'(occ) + int'(inflight)) < CAP);

  always_ff @(posedge clk) begin
    if (rst) up_proto_err <= 1'b0;
    else     up_proto_err <= up_valid & ~ready_cycle;
  end

  assign {dn_data, dn_chan, dn_err} = out_beat;
endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
  parameter int DATA_W = 8,
  parameter int CHAN_W = 2,
  parameter int ERR_W  = 1,
  parameter int LAT    = 2,
  localparam int DEPTH = slb_pkg::slb_depth(LAT),
  localparam int CAP   = DEPTH + 1,
  localparam int OW    = $clog2(DEPTH + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              up_ready,
  input logic              up_valid,
  input logic              up_proto_err,
  input logic              dn_valid,
  input logic              dn_ready,
  input logic [DATA_W-1:0] dn_data,
  input logic [CHAN_W-1:0] dn_chan,
  input logic [ERR_W-1:0]  dn_err,
  input logic              ready_cycle,
  input logic [OW-1:0]     occ
);
  a_r1_reset_ready: assert property (@(posedge clk) rst |-> !up_ready);
  a_r1_reset_dn:    assert property (@(posedge clk) rst |=> !dn_valid);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= CAP);
  a_r3_credit_room: assert property (@(posedge clk) disable iff (rst)
    up_ready |-> (int'(occ) < CAP));

  a_r4_proto_flag:  assert property (@(posedge clk) disable iff (rst)
    (up_valid && !ready_cycle) |=> up_proto_err);

  a_r5_hold_stall:  assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=>
      (dn_valid && $stable(dn_data) && $stable(dn_chan) && $stable(dn_err)));
endmodule

bind stream_latency_bridge slb_checker #(
  .DATA_W(DATA_W), .CHAN_W(CHAN_W), .ERR_W(ERR_W), .LAT(LAT)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .up_ready     (up_ready),
  .up_valid     (up_valid),
  .up_proto_err (up_proto_err),
  .dn_valid     (dn_valid),
  .dn_ready     (dn_ready),
  .dn_data      (dn_data),
  .dn_chan      (dn_chan),
  .dn_err       (dn_err),
  .ready_cycle  (ready_cycle),
  .occ          (occ)
);

// File: tb/stream_latency_bridge_bench.sv
`timescale 1ns/1ps
module stream_latency_bridge_bench;
  localparam int DATA_W = 8;
  localparam int CHAN_W = 2;
  localparam int ERR_W  = 1;
  localparam int LAT    = 2;
  localparam int DEPTH  = 4;          // smallest power of two >= LAT+2
  localparam int CAP    = DEPTH + 1;
  localparam int BW     = DATA_W + CHAN_W + ERR_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              up_ready, up_valid, up_proto_err;
  logic [DATA_W-1:0] up_data;
  logic [CHAN_W-1:0] up_chan;
  logic [ERR_W-1:0]  up_err;
  logic              dn_valid, dn_ready;
  logic [DATA_W-1:0] dn_data;
  logic [CHAN_W-1:0] dn_chan;
  logic [ERR_W-1:0]  dn_err;

  always #10 clk = ~clk;

  stream_latency_bridge #(
    .DATA_W(DATA_W), .CHAN_W(CHAN_W), .ERR_W(ERR_W), .LAT(LAT)
  ) u_stream_latency_bridge (
    .clk(clk), .rst(rst), .up_ready(up_ready), .up_valid(up_valid),
    .up_data(up_data), .up_chan(up_chan), .up_err(up_err),
    .up_proto_err(up_proto_err), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_data(dn_data), .dn_chan(dn_chan), .dn_err(dn_err)
  );

  int            n_checks = 0;
  int            n_fails  = 0;
  logic [BW-1:0] sb [$];
  logic [LAT-1:0] rh = '0;
  logic [15:0]   lf = 16'hACE1;
  logic [7:0]    seq = 8'd0;
  bit            inj_prev = 1'b0;
  bit            stall_prev = 1'b0;
  logic [BW-1:0] held;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_phase(input int dmode, input int smode, input bit inj, input int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      logic          dr;
      logic [BW-1:0] got, exp;
      @(negedge clk);
      // R4: flag follows an illegal valid by one cycle, and only then
      check(up_proto_err == inj_prev, "R4", up_proto_err, inj_prev);
      // R5: stalled output held
      if (stall_prev) begin
        got = {dn_data, dn_chan, dn_err};
        check(dn_valid && got == held, "R5", {dn_valid, got}, {1'b1, held});
      end
      case (dmode)
        0:       dr = 1'b1;
        1:       dr = 1'b0;
        2:       dr = i[0];
        default: dr = lf[0];
      endcase
      if (dn_valid && dr) begin
        got = {dn_data, dn_chan, dn_err};
        if (sb.size() == 0) check(1'b0, "R6", got, 0);
        else begin
          exp = sb.pop_front();
          check(got == exp, "R6", got, exp);
        end
      end
      stall_prev = dn_valid && !dr;
      held = {dn_data, dn_chan, dn_err};
      // R2/R7: send only in bench-tracked ready cycles; garbage otherwise
      if (rh[LAT-1] && (smode == 0 || (smode == 1 && lf[1]))) begin
        up_valid = 1'b1;
        up_data  = seq;
        up_chan  = lf[4:3];
        up_err   = lf[5];
        sb.push_back({seq, lf[4:3], lf[5]});
        seq++;
        inj_prev = 1'b0;
      end else if (!rh[LAT-1] && inj && lf[2]) begin
        up_valid = 1'b1;                  // R4: illegal beat
        up_data  = ~lf[7:0];
        up_chan  = lf[9:8];
        up_err   = lf[6];
        inj_prev = 1'b1;
      end else begin
        up_valid = 1'b0;                  // R7: bus holds junk
        up_data  = lf[15:8];
        up_chan  = lf[11:10];
        up_err   = lf[12];
        inj_prev = 1'b0;
      end
      if (dmode == 0 && smode == 0)
        check(up_ready == 1'b1, "R8", up_ready, 1);
      check(sb.size() <= CAP, "R3", sb.size(), CAP);
      rh = {rh[LAT-2:0], up_ready};
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      dn_ready = dr;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst = 1'b1; up_valid = 1'b0; dn_ready = 1'b0;
    up_data = '0; up_chan = '0; up_err = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!up_ready, "R1", up_ready, 0);
      if (k > 0) check(!dn_valid, "R1", dn_valid, 0);
    end
    rst = 1'b0;
    #1;
    check(up_ready == 1'b1, "R1", up_ready, 1);
    check(dn_valid == 1'b0, "R1", dn_valid, 0);
    rh = {rh[LAT-2:0], up_ready};
    for (int d = 0; d < 4; d++)
      for (int s = 0; s < 2; s++)
        for (int j = 0; j < 2; j++) begin
          run_phase(d, s, j[0], 300);
          run_phase(0, 2, 1'b0, 40);      // drain, source silent
          check(sb.size() == 0, "R3", sb.size(), 0);
        end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule